// File: doc/BRIEF.md
# Flash Toggle-Bit Status Responder

This block supplies the read-status behaviour of one flash bank while an embedded program or erase algorithm runs. It watches the host read strobes (active-low chip enable and output enable) together with busy, erase-suspend and protection indications from the rest of the bank. While an operation is active, each read returns a status word instead of array data. Bit 6 of that word inverts once for every new read cycle. A new read cycle starts when both strobes are low after at least one of them was high.

A command is announced with a one-cycle `cmdStart` pulse, which marks the final write-enable rising edge of the command sequence. It carries the command kind and whether the target sector is protected. For a protected target the block runs its own timer: it reports toggling status for a fixed number of cycles and then returns to array data. Separate timer lengths apply to program and erase. A busy/ready indication for asynchronous mode is modelled as an open-drain pin: an output enable plus a data bit that is always low.

Top module: `flash_toggle_status`

## Requirements
- R1: After reset, `dataOut` is 0 and `rdyOe` is 0. The toggle state starts at 0.
- R2: A new read cycle starts when `ceN` and `oeN` are both low and at least one of them was high in the previous cycle. While the bank is active, each new read cycle inverts bit 6 of the returned status word, and the new value is visible on `dataOut` one clock after the strobes are sampled low. The first read after a command returns bit 6 = 1.
- R3: While both strobes stay low, the returned word, including bit 6, does not change.
- R4: The bank is active when `pgmBusy` is 1, or when `eraseBusy` is 1 and `eraseSusp` is 0, or while a protect interval runs. Whenever the bank is not active, a read returns `arrayData` unchanged and bit 6 keeps its stored value.
- R5: In erase suspend with no program running (`eraseBusy`=1, `eraseSusp`=1, `pgmBusy`=0), `rdyOe` is 0, reads return array data, and bit 6 does not toggle.
- R6: A program that runs during erase suspend (`pgmBusy`=1) makes the bank active. Bit 6 resumes toggling from its stored value, and `rdyOe` is 1 until the program ends.
- R7: `cmdStart` with `targetProt`=1 and `cmdIsErase`=0 keeps the bank active, with `rdyOe`=1, for exactly `PGM_PROT_CYCLES` clock cycles after the pulse. After that, reads return array data.
- R8: `cmdStart` with `targetProt`=1 and `cmdIsErase`=1 keeps the bank active for exactly `ERS_PROT_CYCLES` clock cycles after the pulse.
- R9: `rdyOe` equals 1 exactly when the bank is active. `rdyOut` is always 0.
- R10: `cmdStart` clears the toggle state to 0. If `cmdStart` arrives in the same cycle as the start of a read cycle, the clear wins and that read returns bit 6 = 0.
- R11: The status word has bit 6 = toggle state and bit 2 = toggle state AND (latched command kind is erase). All other bits are 0.
- R12: When the strobes were not both low at the previous clock edge, `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable read strobe |
| oeN | input | 1 | Active-low output enable read strobe |
| cmdStart | input | 1 | One-cycle pulse: command sequence completed |
| cmdIsErase | input | 1 | Command kind at `cmdStart`: 1 erase, 0 program |
| targetProt | input | 1 | At `cmdStart`: target sector(s) protected |
| pgmBusy | input | 1 | Embedded program running (also during erase suspend) |
| eraseBusy | input | 1 | Embedded erase in progress, including its timeout window |
| eraseSusp | input | 1 | Erase suspended |
| arrayData | input | DATA_W | Array word for normal reads |
| dataOut | output | DATA_W | Read data: status word or array word |
| rdyOe | output | 1 | Drive enable of the busy pin (1 = pull low, busy) |
| rdyOut | output | 1 | Busy pin data value, constant 0 |

## Verification
A wrong toggle register appears on the very next read: bit 6 repeats or skips instead of alternating, or it fails to read 1 right after a command. A stuck edge detector shows up within one held read, because bit 6 then changes inside a single strobe-low window. A protect counter that is off by any amount changes the measured busy window by that many cycles, and that window is counted exactly, cycle by cycle, against the parameter. An error in the active decode shows on `rdyOe` at once and on the data mux at the next read.

// File: rtl/fts_pkg.sv
package fts_pkg;
  // Strobes from the control module to the datapath.
  typedef struct packed {
    logic clearTog;     // new command: reset toggle state
    logic flipTog;      // new active read cycle: invert toggle state
    logic loadProt;     // start protect interval
    logic protIsErase;  // choose the erase interval length when loading
    logic cancelProt;   // new unprotected command: stop any interval
    logic latchKind;    // capture the command kind
    logic kindErase;    // command kind to capture
    logic readNow;      // both strobes low this cycle
    logic statusSel;    // return status instead of array data
  } ftsStrobes_t;
endpackage

// File: rtl/fts_ctrl.sv
module fts_ctrl
  import fts_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ceN,
  input  logic        oeN,
  input  logic        cmdStart,
  input  logic        cmdIsErase,
  input  logic        targetProt,
  input  logic        pgmBusy,
  input  logic        eraseBusy,
  input  logic        eraseSusp,
  input  logic        protRun,
  output ftsStrobes_t strobes,
  output logic        bankActive
);
  logic rdNow;
  logic rdPrev;
  logic rdStart;

  assign rdNow   = !ceN && !oeN;
  assign rdStart = rdNow && !rdPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) rdPrev <= 1'b0;
    else        rdPrev <= rdNow;
  end

  // Erase counts only when not suspended; a program counts always.
  assign bankActive = pgmBusy || (eraseBusy && !eraseSusp) || protRun;

  always_comb begin
    strobes             = '0;
    strobes.clearTog    = cmdStart;
    strobes.flipTog     = bankActive && rdStart && !cmdStart;
    strobes.loadProt    = cmdStart && targetProt;
    strobes.protIsErase = cmdIsErase;
    strobes.cancelProt  = cmdStart && !targetProt;
    strobes.latchKind   = cmdStart;
    strobes.kindErase   = cmdIsErase;
    strobes.readNow     = rdNow;
    strobes.statusSel   = bankActive;
  end
endmodule

// File: rtl/fts_datapath.sv
module fts_datapath
  import fts_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int TOG_BIT         = 6,
  parameter int AUX_BIT         = 2,
  parameter bit AUX_MIRROR      = 1'b1,
  parameter int PGM_PROT_CYCLES = 20,
  parameter int ERS_PROT_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ftsStrobes_t       strobes,
  input  logic [DATA_W-1:0] arrayData,
  output logic              protRun,
  output logic [DATA_W-1:0] dataOut
);
  localparam int MAX_CYC = (PGM_PROT_CYCLES > ERS_PROT_CYCLES) ? PGM_PROT_CYCLES : ERS_PROT_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] PGM_LEN = CNT_W'(PGM_PROT_CYCLES);
  localparam logic [CNT_W-1:0] ERS_LEN = CNT_W'(ERS_PROT_CYCLES);

  logic             togReg;
  logic             kindReg;
  logic             readReg;
  logic [CNT_W-1:0] protCnt;
  logic             auxVal;
  logic [DATA_W-1:0] statusWord;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      togReg  <= 1'b0;
      kindReg <= 1'b0;
      readReg <= 1'b0;
    end else begin
      readReg <= strobes.readNow;
      if (strobes.latchKind) kindReg <= strobes.kindErase;
      if (strobes.clearTog)     togReg <= 1'b0;
      else if (strobes.flipTog) togReg <= ~togReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  protCnt <= '0;
    else if (strobes.loadProt)   protCnt <= strobes.protIsErase ? ERS_LEN : PGM_LEN;
    else if (strobes.cancelProt) protCnt <= '0;
    else if (protCnt != '0)      protCnt <= protCnt - 1'b1;
  end

  assign protRun = (protCnt != '0);

  generate
    if (AUX_MIRROR) begin : g_auxMirror
      assign auxVal = togReg && kindReg;
    end else begin : g_auxZero
      assign auxVal = 1'b0;
    end
  endgenerate

  always_comb begin
    statusWord          = '0;
    statusWord[TOG_BIT] = togReg;
    statusWord[AUX_BIT] = auxVal;
  end

  always_comb begin
    if (!readReg)               dataOut = '0;
    else if (strobes.statusSel) dataOut = statusWord;
    else                        dataOut = arrayData;
  end
endmodule

// File: rtl/flash_toggle_status.sv
module flash_toggle_status
  import fts_pkg::*;
#(
  parameter int DATA_W          = 16,
  parameter int PGM_PROT_CYCLES = 20,
  parameter int ERS_PROT_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              cmdStart,
  input  logic              cmdIsErase,
  input  logic              targetProt,
  input  logic              pgmBusy,
  input  logic              eraseBusy,
  input  logic              eraseSusp,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              rdyOe,
  output logic              rdyOut
);
  ftsStrobes_t strobes;
  logic        protRun;
  logic        bankActive;

  fts_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .oeN(oeN),
    .cmdStart(cmdStart), .cmdIsErase(cmdIsErase), .targetProt(targetProt),
    .pgmBusy(pgmBusy), .eraseBusy(eraseBusy), .eraseSusp(eraseSusp),
    .protRun(protRun), .strobes(strobes), .bankActive(bankActive)
  );

  fts_datapath #(
    .DATA_W(DATA_W), .TOG_BIT(6), .AUX_BIT(2), .AUX_MIRROR(1'b1),
    .PGM_PROT_CYCLES(PGM_PROT_CYCLES), .ERS_PROT_CYCLES(ERS_PROT_CYCLES)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .arrayData(arrayData),
    .protRun(protRun), .dataOut(dataOut)
  );

  assign rdyOe  = bankActive;
  assign rdyOut = 1'b0;
endmodule

// File: rtl/fts_checker.sv
module fts_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ceN,
  input logic              oeN,
  input logic              cmdStart,
  input logic              targetProt,
  input logic              pgmBusy,
  input logic [DATA_W-1:0] dataOut,
  input logic              rdyOe
);
  logic       rd;
  logic [1:0] ageCnt;
  assign rd = !ceN && !oeN;

  always_ff @(posedge clk) begin
    if (!rst_n)               ageCnt <= '0;
    else if (ageCnt != 2'd3)  ageCnt <= ageCnt + 2'd1;
  end

  // R9: a running program always drives the busy pin
  assert_busy_pgm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pgmBusy |-> rdyOe);

  // R12: no read sampled at the last edge gives a zero bus
  assert_idle_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ageCnt != 2'd0 && !$past(rd)) |-> (dataOut == '0));

  // R7: a protected command makes the bank busy on the next cycle
  assert_prot_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdStart && targetProt) |=> rdyOe);

  // R3: a held read keeps the status bit steady
  assert_hold_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ageCnt == 2'd3 && $past(rd) && $past(rd, 2) && !$past(cmdStart)
     && rdyOe && $past(rdyOe)) |-> (dataOut[6] == $past(dataOut[6])));
endmodule

bind flash_toggle_status fts_checker #(.DATA_W(DATA_W)) u_fts_chk (
  .clk(clk), .rst_n(rst_n), .ceN(ceN), .oeN(oeN), .cmdStart(cmdStart),
  .targetProt(targetProt), .pgmBusy(pgmBusy), .dataOut(dataOut), .rdyOe(rdyOe)
);

// File: tb/flash_toggle_status_test.sv
`timescale 1ns/1ps
module flash_toggle_status_test;
  localparam int DW  = 16;
  localparam int PGM = 20;
  localparam int ERS = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ceN = 1'b1, oeN = 1'b1;
  logic cmdStart = 1'b0, cmdIsErase = 1'b0, targetProt = 1'b0;
  logic pgmBusy = 1'b0, eraseBusy = 1'b0, eraseSusp = 1'b0;
  logic [DW-1:0] arrayData = 16'hA5C3;
  logic [DW-1:0] dataOut;
  logic rdyOe, rdyOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_toggle_status #(.DATA_W(DW), .PGM_PROT_CYCLES(PGM), .ERS_PROT_CYCLES(ERS)) uut (
    .clk(clk), .rst_n(rst_n), .ceN(ceN), .oeN(oeN), .cmdStart(cmdStart),
    .cmdIsErase(cmdIsErase), .targetProt(targetProt), .pgmBusy(pgmBusy),
    .eraseBusy(eraseBusy), .eraseSusp(eraseSusp), .arrayData(arrayData),
    .dataOut(dataOut), .rdyOe(rdyOe), .rdyOut(rdyOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One read cycle; drops both strobes (or only oeN if ceN already low).
  task automatic doRead(input string req, input logic [DW-1:0] exp, input bit keepCe);
    logic [DW-1:0] first;
    @(negedge clk); ceN = 1'b0; oeN = 1'b0;
    @(negedge clk); first = dataOut;
    check(req, first, exp);
    @(negedge clk);
    check("R3 held read", dataOut, first);
    oeN = 1'b1;
    if (!keepCe) ceN = 1'b1;
    @(negedge clk);
    check("R12 idle bus", dataOut, '0);
  endtask

  task automatic startCmd(input bit isErase, input bit prot);
    @(negedge clk); cmdStart = 1'b1; cmdIsErase = isErase; targetProt = prot;
    @(negedge clk); cmdStart = 1'b0; targetProt = 1'b0;
  endtask

  task automatic testReset();
    check("R1 dataOut", dataOut, '0);
    check("R1 rdyOe", rdyOe, 1'b0);
    check("R9 rdyOut", rdyOut, 1'b0);
  endtask

  task automatic testProgram();
    startCmd(1'b0, 1'b0);
    pgmBusy = 1'b1;
    @(negedge clk);
    check("R9 busy on program", rdyOe, 1'b1);
    doRead("R2 first read", 16'h0040, 1'b1);
    doRead("R2 oe-only toggle", 16'h0000, 1'b1);
    doRead("R2 third read", 16'h0040, 1'b0);
    pgmBusy = 1'b0;
    @(negedge clk);
    check("R9 ready", rdyOe, 1'b0);
    doRead("R4 array after done", 16'hA5C3, 1'b0);
    check("R9 rdyOut", rdyOut, 1'b0);
  endtask

  task automatic testErase();
    arrayData = 16'h3C5A;
    startCmd(1'b1, 1'b0);
    eraseBusy = 1'b1;
    doRead("R11 erase status", 16'h0044, 1'b0);
    doRead("R11 erase status", 16'h0000, 1'b0);
    eraseSusp = 1'b1;
    @(negedge clk);
    check("R5 suspend ready", rdyOe, 1'b0);
    doRead("R5 suspend read", 16'h3C5A, 1'b0);
    doRead("R5 suspend read 2", 16'h3C5A, 1'b0);
    pgmBusy = 1'b1;
    @(negedge clk);
    check("R6 suspend program busy", rdyOe, 1'b1);
    doRead("R6 suspend program toggle", 16'h0044, 1'b0);
    doRead("R6 suspend program toggle", 16'h0000, 1'b0);
    pgmBusy = 1'b0;
    doRead("R6 program done", 16'h3C5A, 1'b0);
    eraseSusp = 1'b0; eraseBusy = 1'b0;
    @(negedge clk);
  endtask

  task automatic measureProt(input string req, input bit isErase, input int expLen);
    int cnt = 0;
    @(negedge clk); cmdStart = 1'b1; cmdIsErase = isErase; targetProt = 1'b1;
    @(negedge clk); cmdStart = 1'b0; targetProt = 1'b0;
    while (rdyOe && cnt < 1000) begin
      cnt++;
      @(negedge clk);
    end
    check(req, cnt, expLen);
  endtask

  task automatic testProtect();
    arrayData = 16'h1234;
    measureProt("R7 program protect length", 1'b0, PGM);
    doRead("R7 array after protect", 16'h1234, 1'b0);
    measureProt("R8 erase protect length", 1'b1, ERS);
    doRead("R8 array after protect", 16'h1234, 1'b0);
  endtask

  task automatic testClear();
    startCmd(1'b0, 1'b0);
    pgmBusy = 1'b1;
    doRead("R2 first", 16'h0040, 1'b0);
    startCmd(1'b0, 1'b0);
    doRead("R10 clear restarts", 16'h0040, 1'b0);
    @(negedge clk); cmdStart = 1'b1; cmdIsErase = 1'b0; ceN = 1'b0; oeN = 1'b0;
    @(negedge clk); cmdStart = 1'b0;
    check("R10 clear wins", dataOut, 16'h0000);
    @(negedge clk); ceN = 1'b1; oeN = 1'b1;
    doRead("R10 next read", 16'h0040, 1'b0);
    pgmBusy = 1'b0;
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    testProgram();
    testErase();
    testProtect();
    testClear();
    finishRun();
  end

  initial begin
    #(8 * 100000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end
endmodule